// File: doc/BRIEF.md
# Clause 22 Management Interface Master

This block runs management transactions to Ethernet PHYs over the two-wire serial management bus (MDC clock, bidirectional MDIO data). Software controls it through two registers on a small register port. A command register holds the PHY address, the PHY register number, a clock-range code and the operation. A data register holds the 16-bit value to send on a write, or the value returned by a read. Setting the go/busy bit in the command register starts a frame. The bit reads back as 1 until the last bit has left the wire, and then clears by itself.

Software writes the data register first when it needs to, then writes the command word with bit 0 set, and then polls bit 0 until it reads low. The parameter `ALT_OPCODE` selects how the operation is coded in the command word. The clock-range code selects the MDC rate. Between frames MDC stays low and MDIO is not driven.

The register port is a plain control interface with no handshake. A write takes effect on the clock edge where `reg_wr` is high. `reg_rdata` is combinational from `reg_sel`.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, both registers read 0, `mdc` is low and `mdio_oe` is low.
- R2: A write to the command register (`reg_sel`=0) with bit 0 set starts a frame when the block is idle and the operation code is valid. Bit 0 then reads 1 until the frame ends and clears on its own. A command write made while busy changes nothing: the command readback keeps its value.
- R3: With `ALT_OPCODE`=0, command bit 1 selects the operation: 1 is a write and 0 is a read. The clock code sits at bits 5:2.
- R4: With `ALT_OPCODE`=1, command bits 3:2 select the operation: 01 is a write and 11 is a read. The clock code sits at bits 19:16. The codes 00 and 10 start nothing, so busy stays clear and `mdc` stays low.
- R5: The PHY address is taken from command bits 15:11 and the register number from bits 10:6. A frame is 64 bits sent MSB first: 32 ones, start `01`, opcode (`10` read, `01` write), 5-bit PHY address, 5-bit register number, turnaround (`10`), then 16 data bits.
- R6: MDIO changes only while `mdc` is low. One frame has exactly 64 rising edges of `mdc`, and `mdc` is low whenever the block is idle.
- R7: On a write the master drives MDIO for all 64 bits. On a read it drives the first 46 bits and releases MDIO from the turnaround to the end of the frame.
- R8: A read samples MDIO on the rising `mdc` edges of the 16 data bits. When the frame ends, the data register (`reg_sel`=1, bits 15:0) holds that value, MSB first.
- R9: Each half period of `mdc` lasts 2*(code+1) clock cycles, so busy stays high for 256*(code+1) cycles.
- R10: A write to the data register while busy is ignored. A completed write frame leaves the data register unchanged.
- R11: All PHY addresses from 0 to 31 are usable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the command register, 1 selects the data register |
| reg_wdata | input | CMD_W | Register write data |
| reg_rdata | output | CMD_W | Readback of the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The assertions assume that software only starts a command after it has seen busy low. They also assume that the register inputs are defined whenever `reg_wr` is high. They treat `mdio_i` as don't-care except during the read data phase. The bench drives every register access at the falling clock edge. Its PHY model changes `mdio_i` only on the falling edge of `mdc`, and drives only during the turnaround and data phase of a read. Writes made during busy are placed deliberately in the middle of a frame, so that the ignore rules are exercised without breaking the poll-before-issue rule.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int IDX_W      = 6;
  localparam int DATA_W     = 16;
  localparam int RD_RELEASE = 46;   // first bit index the master releases on a read

  typedef enum logic {SEL_CMD = 1'b0, SEL_DATA = 1'b1} reg_sel_e;

  function automatic logic [FRAME_BITS-1:0] build_frame(
      input logic              is_read,
      input logic [4:0]        phy,
      input logic [4:0]        regn,
      input logic [DATA_W-1:0] wdata);
    logic [1:0] op;
    op = is_read ? 2'b10 : 2'b01;
    return {32'hFFFF_FFFF, 2'b01, op, phy, regn, 2'b10,
            is_read ? {DATA_W{1'b0}} : wdata};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CODE_W-1:0] code,
  output logic              mdc,
  output logic              rise_p,
  output logic              fall_p
);
  localparam int CNT_W = CODE_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_m1;
  logic             wrap;

  // half period = 2*(code+1) cycles
  assign half_m1 = {code, 1'b1};
  assign wrap    = en && (cnt == half_m1);
  assign rise_p  = wrap && !mdc;
  assign fall_p  = wrap && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r9_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt <= half_m1));
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_read,
  input  logic [4:0]        phy,
  input  logic [4:0]        regn,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_p,
  input  logic              fall_p,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  logic                  active;
  logic                  rd_q;
  logic [IDX_W-1:0]      idx;
  logic [FRAME_BITS-1:0] shreg;

  assign mdio_o  = shreg[FRAME_BITS-1];
  assign mdio_oe = active && !(rd_q && (idx >= IDX_W'(RD_RELEASE)));
  assign done    = active && fall_p && (idx == IDX_W'(FRAME_BITS-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      rd_q   <= 1'b0;
      idx    <= '0;
      shreg  <= '0;
      rdata  <= '0;
    end else if (start) begin
      active <= 1'b1;
      rd_q   <= is_read;
      idx    <= '0;
      shreg  <= build_frame(is_read, phy, regn, wdata);
    end else if (active) begin
      if (rise_p && rd_q)
        rdata <= {rdata[DATA_W-2:0], mdio_i};
      if (fall_p) begin
        if (done) begin
          active <= 1'b0;
          shreg  <= '0;
        end else begin
          idx   <= idx + 1'b1;
          shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end

  a_r7_released_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (active && rd_q && idx >= IDX_W'(RD_RELEASE)) |-> !mdio_oe);
  a_r6_no_start_when_active: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> !start);
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter bit ALT_OPCODE     = 1'b0,
  parameter int CMD_W          = 20,
  parameter int PHY_LSB        = 11,
  parameter int REG_LSB        = 6,
  parameter int CLK_LSB_LEGACY = 2,
  parameter int CLK_LSB_ALT    = 16,
  parameter int CODE_W         = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [CMD_W-1:0] reg_wdata,
  output logic [CMD_W-1:0] reg_rdata,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  localparam int CLK_LSB = ALT_OPCODE ? CLK_LSB_ALT : CLK_LSB_LEGACY;

  logic              busy;
  logic [CMD_W-1:0]  cmd_q;
  logic [DATA_W-1:0] data_q;
  logic [CODE_W-1:0] code_q;
  logic              rd_q;
  logic              op_valid, op_read;
  logic              cmd_wr, data_wr, start;
  logic              rise_p, fall_p, done;
  logic [DATA_W-1:0] cap;

  generate
    if (ALT_OPCODE) begin : g_alt_op
      assign op_valid = reg_wdata[2];     // 01 write, 11 read
      assign op_read  = reg_wdata[3];
    end else begin : g_legacy_op
      assign op_valid = 1'b1;
      assign op_read  = ~reg_wdata[1];
    end
  endgenerate

  assign cmd_wr  = reg_wr && (reg_sel == SEL_CMD) && !busy;
  assign data_wr = reg_wr && (reg_sel == SEL_DATA) && !busy;
  assign start   = cmd_wr && reg_wdata[0] && op_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cmd_q  <= '0;
      data_q <= '0;
      code_q <= '0;
      rd_q   <= 1'b0;
    end else begin
      if (cmd_wr) begin
        cmd_q  <= {reg_wdata[CMD_W-1:1], 1'b0};
        code_q <= reg_wdata[CLK_LSB +: CODE_W];
        rd_q   <= op_read;
      end
      if (start)
        busy <= 1'b1;
      else if (done)
        busy <= 1'b0;
      if (done && rd_q)
        data_q <= cap;
      else if (data_wr)
        data_q <= reg_wdata[DATA_W-1:0];
    end
  end

  assign reg_rdata = (reg_sel == SEL_DATA) ? CMD_W'(data_q)
                                           : {cmd_q[CMD_W-1:1], busy};

  mdio_clkgen #(.CODE_W(CODE_W)) u_clk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (busy),
    .code   (code_q),
    .mdc    (mdc),
    .rise_p (rise_p),
    .fall_p (fall_p)
  );

  mdio_frame u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .is_read (op_read),
    .phy     (reg_wdata[PHY_LSB +: 5]),
    .regn    (reg_wdata[REG_LSB +: 5]),
    .wdata   (data_q),
    .rise_p  (rise_p),
    .fall_p  (fall_p),
    .mdio_i  (mdio_i),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .done    (done),
    .rdata   (cap)
  );

  a_r6_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  a_r6_mdio_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> !mdc);
  a_r2_cmd_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_sel == SEL_CMD) |=> $stable(cmd_q));
  a_r10_data_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_sel == SEL_DATA && !done) |=> $stable(data_q));
  a_r7_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);
endmodule

// File: tb/tb_mdio_mgmt_master.sv
module tb_mdio_mgmt_master;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic          wr   [2];
  logic          sel  [2];
  logic [CW-1:0] wd   [2];
  logic [CW-1:0] rd   [2];
  logic          mdc  [2];
  logic          mo   [2];
  logic          moe  [2];
  logic          mi   [2];

  int checks = 0;
  int failures = 0;
  longint cyc = 0;
  int rise_cnt [2];
  int oe_cnt   [2];
  int base_r   [2];
  int base_oe  [2];
  logic        rd_mode [2];
  logic [15:0] phy_val [2];
  logic [63:0] wire_cap [2];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mdio_mgmt_master #(.ALT_OPCODE(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr[0]), .reg_sel(sel[0]), .reg_wdata(wd[0]),
    .reg_rdata(rd[0]), .mdc(mdc[0]), .mdio_o(mo[0]), .mdio_oe(moe[0]), .mdio_i(mi[0]));
  mdio_mgmt_master #(.ALT_OPCODE(1'b1)) dut_alt (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr[1]), .reg_sel(sel[1]), .reg_wdata(wd[1]),
    .reg_rdata(rd[1]), .mdc(mdc[1]), .mdio_o(mo[1]), .mdio_oe(moe[1]), .mdio_i(mi[1]));

  // PHY model: samples on rising MDC, drives on falling MDC
  for (genvar g = 0; g < 2; g++) begin : g_phy
    initial begin
      rise_cnt[g] = 0; oe_cnt[g] = 0; wire_cap[g] = '0; mi[g] = 1'b1;
    end
    always @(posedge mdc[g]) begin
      wire_cap[g] = {wire_cap[g][62:0], moe[g] ? mo[g] : mi[g]};
      if (moe[g]) oe_cnt[g] = oe_cnt[g] + 1;
      rise_cnt[g] = rise_cnt[g] + 1;
    end
    always @(negedge mdc[g]) begin
      int n;
      n = rise_cnt[g] - base_r[g];
      if (rd_mode[g] && n == 47) mi[g] = 1'b0;
      else if (rd_mode[g] && n >= 48 && n < 64) mi[g] = phy_val[g][63-n];
      else mi[g] = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input int m, input bit s, input logic [CW-1:0] d);
    @(negedge clk);
    wr[m] = 1'b1; sel[m] = s; wd[m] = d;
    @(negedge clk);
    wr[m] = 1'b0; sel[m] = 1'b0;
  endtask

  task automatic reg_read(input int m, input bit s, output logic [CW-1:0] d);
    sel[m] = s; #1; d = rd[m]; sel[m] = 1'b0; #1;
  endtask

  function automatic logic [CW-1:0] mk_cmd(input int m, input bit w, input int phy,
                                           input int rg, input int code);
    logic [CW-1:0] c;
    c = CW'(phy % 32) << 11 | CW'(rg % 32) << 6 | CW'(1);
    if (m == 0) c = c | CW'(code) << 2 | CW'(w) << 1;
    else        c = c | CW'(code) << 16 | (w ? CW'(4'b0100) : CW'(4'b1100));
    return c;
  endfunction

  task automatic do_op(input int m, input bit w, input int phy, input int rg,
                       input int code, input bit poke);
    logic [15:0] d, junk;
    logic [CW-1:0] cmd, r;
    logic [63:0] exp_f;
    longint s, dur;
    d = w ? 16'((phy * 1237 + rg * 71 + 5) & 16'hFFFF) : 16'h0;
    phy_val[m] = {5'(phy), 5'(rg), ~5'(phy), 1'b1};
    if (w) reg_write(m, 1'b1, CW'(d));
    cmd = mk_cmd(m, w, phy, rg, code);
    base_r[m] = rise_cnt[m]; base_oe[m] = oe_cnt[m]; rd_mode[m] = !w;
    reg_write(m, 1'b0, cmd);
    s = cyc;
    reg_read(m, 1'b0, r);
    chk(r == cmd, "R2 busy readback", r, cmd);
    if (poke) begin
      junk = ~d;
      reg_write(m, 1'b0, cmd ^ CW'(20'hF8FC0));
      reg_read(m, 1'b0, r);
      chk(r == cmd, "R2 cmd write while busy", r, cmd);
      reg_write(m, 1'b1, CW'(junk));
      reg_read(m, 1'b1, r);
      chk(r[15:0] == d, "R10 data write while busy", r, d);
    end
    while (1) begin
      reg_read(m, 1'b0, r);
      if (!r[0]) break;
      @(negedge clk);
    end
    dur = cyc - s;
    chk(dur == 256 * (code + 1), "R9 busy duration", dur, 256 * (code + 1));
    chk(rise_cnt[m] - base_r[m] == 64, "R6 rising edges", rise_cnt[m] - base_r[m], 64);
    chk(mdc[m] == 1'b0 && moe[m] == 1'b0, "R6 idle after frame", {mdc[m], moe[m]}, 0);
    chk(oe_cnt[m] - base_oe[m] == (w ? 64 : 46), "R7 driven bits",
        oe_cnt[m] - base_oe[m], w ? 64 : 46);
    exp_f = {32'hFFFF_FFFF, 2'b01, w ? 2'b01 : 2'b10, 5'(phy), 5'(rg), 2'b10,
             w ? d : phy_val[m]};
    chk(wire_cap[m] == exp_f, w ? (m ? "R4 R5 R11 write frame" : "R3 R5 R11 write frame")
                                : (m ? "R4 R5 R11 read frame" : "R3 R5 R11 read frame"),
        wire_cap[m], exp_f);
    reg_read(m, 1'b1, r);
    if (w) chk(r[15:0] == d, "R10 data kept after write", r, d);
    else   chk(r[15:0] == phy_val[m], "R8 read data", r, phy_val[m]);
    rd_mode[m] = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 5_000_000; i++) begin
      #(CLK_PERIOD);
      if (cyc >= 200000) begin
        failures++; checks++;
        $display("FAIL watchdog actual=%0d expected=<200000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [CW-1:0] r;
    for (int m = 0; m < 2; m++) begin
      wr[m] = 0; sel[m] = 0; wd[m] = '0; base_r[m] = 0; base_oe[m] = 0;
      rd_mode[m] = 0; phy_val[m] = '0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int m = 0; m < 2; m++) begin
      reg_read(m, 1'b0, r); chk(r == 0, "R1 cmd reset", r, 0);
      reg_read(m, 1'b1, r); chk(r == 0, "R1 data reset", r, 0);
      chk(mdc[m] == 0 && moe[m] == 0, "R1 pins reset", {mdc[m], moe[m]}, 0);
    end
    // R4 invalid alternative opcodes start nothing
    for (int op = 0; op < 4; op += 2) begin
      reg_write(1, 1'b0, CW'(20'h0A841) | CW'(op << 2));
      repeat (20) @(negedge clk);
      reg_read(1, 1'b0, r);
      chk(r[0] == 1'b0 && mdc[1] == 1'b0, "R4 invalid opcode ignored", r, 0);
    end
    // R2 legacy command without go bit starts nothing
    reg_write(0, 1'b0, CW'(20'h0A842));
    repeat (20) @(negedge clk);
    reg_read(0, 1'b0, r);
    chk(r[0] == 1'b0 && mdc[0] == 1'b0, "R2 no go bit no frame", r, 20'h0A842);
    // sweep all PHY addresses in both modes
    for (int m = 0; m < 2; m++)
      for (int p = 0; p < 32; p++)
        do_op(m, p[0], p, (p * 7 + 3) % 32, p % 4, p % 8 == 1);
    // a slow clock code
    do_op(0, 1'b0, 17, 9, 15, 1'b0);
    do_op(1, 1'b1, 30, 31, 15, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule